// File: doc/BRIEF.md
# Display Register Aperture Bridge

This block sits behind one memory-mapped register aperture of a display controller and steers each bus access to one of four places. A 32-byte legacy window turns every byte of an access into a cycle on a byte-wide indexed port bus. The port number is a fixed base of 0x3C0 plus the byte's offset. An extended-mode window turns the access offset into a register index and performs one 16-bit data cycle at that index. A small extension bank, present only when enabled, reports its own size and keeps a framebuffer byte-order flag. An identification region, also optional, is read through a narrow lookup port.

Multi-byte accesses to the legacy window are split into byte cycles, one per clock, in ascending address order. This lets an index port and its data port be written by a single 16-bit store. While the split cycles run the bridge raises `bus_busy` and ignores new strobes. Every accepted access ends with a one-cycle `bus_done` pulse, and for reads `bus_rdata` is valid in that same cycle.

Aperture layout (byte offsets): identification 0x000–0x0FF, legacy window 0x400–0x41F, extended-mode window 0x500–0x515, extension bank 0x600–0x607.

Top module: `mmio_port_bridge`

## Requirements
- R1: During and right after reset, `bus_busy`, `bus_done` and every downstream strobe are low, and `be_fb` is 0 (little-endian).
- R2: A 1-byte access accepted at offset 0x400+N gives exactly one port cycle, at port 0x3C0+N, in the clock after acceptance. `bus_done` follows one clock later.
- R3: A 2-byte or 4-byte legacy write gives 2 or 4 port writes on consecutive clocks at ascending ports 0x3C0+N+k. Byte k of the write data (bits 8k+7:8k) is sent on cycle k, so the low byte goes first.
- R4: A legacy read of 2 or 4 bytes returns the byte read from port 0x3C0+N+k in bits 8k+7:8k. Unused upper bits are zero.
- R5: `bus_busy` is high in every clock that has a downstream strobe. At most one strobe is active per clock. A request presented while busy is dropped.
- R6: An access at 0x500+M drives index M>>1 with `xm_idx_wr` in the first clock after acceptance, then `xm_rd` or `xm_wr` in the next clock. Write data is bits 15:0. A read returns the 16-bit data zero-extended. `bus_done` comes 3 clocks after acceptance.
- R7: With the bank enabled, a 32-bit read (size code 2 or 3) of offset 0x600 returns 8, the bank size.
- R8: A 32-bit write of offset 0x604 sets `be_fb` to 1 only for the value 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value leaves it unchanged. A read of 0x604 returns the code for the current flag. The flag changes in the acceptance clock.
- R9: Other bank offsets read zero, and writes to them are ignored. A bank access of size code 0 or 1 acts as unmapped.
- R10: With the identification region enabled, a read at offset A < 0x100 drives `id_rd` with `id_addr`=A in the clock after acceptance. It returns `id_rdata` masked to the access size (code 0: 8 bits, 1: 16 bits, 2/3: 32 bits). Writes there give no cycle.
- R11: An access to an unmapped offset, or to a disabled region, reads zero, produces no downstream strobe, and ends with `bus_done` in the clock after acceptance.
- R12: `rev_id` is 2 when the extension bank is enabled and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_en | input | 1 | Identification region present |
| xb_en | input | 1 | Extension bank present |
| bus_rd | input | 1 | Read request strobe |
| bus_wr | input | 1 | Write request strobe (wins if both set) |
| bus_addr | input | 11 | Byte offset in the aperture |
| bus_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_busy | output | 1 | Split access in progress; strobes ignored |
| bus_done | output | 1 | One-cycle end-of-access pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_done` |
| lp_rd | output | 1 | Port bus read cycle |
| lp_wr | output | 1 | Port bus write cycle |
| lp_addr | output | 10 | Port number |
| lp_wdata | output | 8 | Port write byte |
| lp_rdata | input | 8 | Port read byte, same cycle |
| xm_idx_wr | output | 1 | Extended-mode index write |
| xm_idx | output | 8 | Extended-mode register index |
| xm_rd | output | 1 | Extended-mode data read |
| xm_wr | output | 1 | Extended-mode data write |
| xm_wdata | output | 16 | Extended-mode write data |
| xm_rdata | input | 16 | Extended-mode read data, same cycle |
| id_rd | output | 1 | Identification lookup strobe |
| id_addr | output | 8 | Identification byte offset |
| id_rdata | input | 32 | Identification data, same cycle |
| be_fb | output | 1 | Framebuffer byte order, 1 = big-endian |
| rev_id | output | 8 | Reported revision value |

## Verification
Latency is fixed by destination and is counted from the acceptance edge. Bank, unmapped and disabled accesses finish with `bus_done` one clock later. An identification read finishes two clocks later. Extended-mode accesses finish three clocks later. A legacy access of n bytes finishes n+1 clocks later, with its port cycles in the n clocks before that. The bench logs every downstream strobe at the falling edge, tagged with how many rising edges have passed since acceptance. It then compares each access's log, its latency and its read data with values computed from the offset, size and data.

// File: rtl/mpb_pkg.sv
// Shared types and constants for the aperture bridge.
// Assumes size code 2'b1x means a 32-bit access.
package mpb_pkg;
    typedef enum logic [2:0] {RG_NONE, RG_ID, RG_LEG, RG_XMODE, RG_XBANK} region_e;
    typedef enum logic [2:0] {S_IDLE, S_LEG, S_XIDX, S_XDAT, S_IDRD} seq_e;

    localparam logic [31:0] ORDER_BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] ORDER_LITTLE = 32'h1E1E_1E1E;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        return sz[1] ? 3'd4 : (sz[0] ? 3'd2 : 3'd1);
    endfunction
endpackage

// File: rtl/mpb_decode.sv
// Region decoder: classifies an aperture offset and returns the offset
// relative to the start of its region. Disabled regions and bank accesses
// narrower than 32 bits decode as RG_NONE. Purely combinational.
module mpb_decode
    import mpb_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ID_SPAN  = 256,
    parameter int LEG_BASE = 'h400,
    parameter int LEG_SPAN = 32,
    parameter int XM_BASE  = 'h500,
    parameter int XM_SPAN  = 'h16,
    parameter int XB_BASE  = 'h600,
    parameter int XB_SPAN  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              id_en,
    input  logic              xb_en,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [31:0] ID_HI  = 32'(ID_SPAN);
    localparam logic [31:0] LEG_LO = 32'(LEG_BASE);
    localparam logic [31:0] LEG_HI = 32'(LEG_BASE + LEG_SPAN);
    localparam logic [31:0] XM_LO  = 32'(XM_BASE);
    localparam logic [31:0] XM_HI  = 32'(XM_BASE + XM_SPAN);
    localparam logic [31:0] XB_LO  = 32'(XB_BASE);
    localparam logic [31:0] XB_HI  = 32'(XB_BASE + XB_SPAN);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    // Pick the region and its local offset.
    always_comb begin
        region = RG_NONE;
        offset = '0;
        if (id_en && a32 < ID_HI) begin
            region = RG_ID;
            offset = addr;
        end else if (a32 >= LEG_LO && a32 < LEG_HI) begin
            region = RG_LEG;
            offset = ADDR_W'(a32 - LEG_LO);
        end else if (a32 >= XM_LO && a32 < XM_HI) begin
            region = RG_XMODE;
            offset = ADDR_W'(a32 - XM_LO);
        end else if (xb_en && size[1] && a32 >= XB_LO && a32 < XB_HI) begin
            region = RG_XBANK;
            offset = ADDR_W'(a32 - XB_LO);
        end
    end
endmodule

// File: rtl/mpb_xbank.sv
// Extension bank: a read-only size word and a byte-order flag that only
// two exact codes can change. The caller qualifies wr_en with the region
// decode, so offsets here are local to the bank.
module mpb_xbank
    import mpb_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int XB_SPAN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] off,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              big_endian
);
    localparam logic [ADDR_W-1:0] OFF_SIZE  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_ORDER = ADDR_W'(4);

    // Byte-order flag; values other than the two codes leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_endian <= 1'b0;
        end else if (wr_en && off == OFF_ORDER) begin
            if (wdata == ORDER_BIG)
                big_endian <= 1'b1;
            else if (wdata == ORDER_LITTLE)
                big_endian <= 1'b0;
        end
    end

    // Read mux: size word, current order code, zero elsewhere.
    always_comb begin
        if (off == OFF_SIZE)
            rdata = 32'(XB_SPAN);
        else if (off == OFF_ORDER)
            rdata = big_endian ? ORDER_BIG : ORDER_LITTLE;
        else
            rdata = '0;
    end
endmodule

// File: rtl/mmio_port_bridge.sv
// Top of the aperture bridge. Accepts one access per idle clock. It runs
// the downstream cycles for legacy, extended-mode and identification
// accesses from a small sequencer, and answers bank and unmapped accesses
// in the acceptance clock. Assumes the port, extended and identification
// read data return combinationally in the strobe cycle.
module mmio_port_bridge
    import mpb_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PORT_W    = 10,
    parameter int PORT_BASE = 'h3C0,
    parameter int XIDX_W    = 8,
    parameter int ID_AW     = 8,
    parameter int BASE_REV  = 1,
    parameter int EXT_REV   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_en,
    input  logic              xb_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_busy,
    output logic              bus_done,
    output logic [31:0]       bus_rdata,
    output logic              lp_rd,
    output logic              lp_wr,
    output logic [PORT_W-1:0] lp_addr,
    output logic [7:0]        lp_wdata,
    input  logic [7:0]        lp_rdata,
    output logic              xm_idx_wr,
    output logic [XIDX_W-1:0] xm_idx,
    output logic              xm_rd,
    output logic              xm_wr,
    output logic [15:0]       xm_wdata,
    input  logic [15:0]       xm_rdata,
    output logic              id_rd,
    output logic [ID_AW-1:0]  id_addr,
    input  logic [31:0]       id_rdata,
    output logic              be_fb,
    output logic [7:0]        rev_id
);
    localparam int LANES = 4;

    region_e           region;
    logic [ADDR_W-1:0] dec_off;
    logic [31:0]       bank_rdata;
    logic              acc;
    logic              bank_wr;

    seq_e              state;
    logic              op_wr;
    logic [ADDR_W-1:0] cap_off;
    logic [1:0]        cap_size;
    logic [31:0]       cap_wdata;
    logic [1:0]        cnt;
    logic [1:0]        last;
    logic [31:0]       rd_buf;
    logic              done_q;
    logic [LANES-1:0]  lane_on;
    logic [31:0]       id_masked;

    mpb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .size   (bus_size),
        .id_en  (id_en),
        .xb_en  (xb_en),
        .region (region),
        .offset (dec_off)
    );

    assign acc     = (bus_rd || bus_wr) && state == S_IDLE;
    assign bank_wr = acc && bus_wr && region == RG_XBANK;

    mpb_xbank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bank_wr),
        .off        (dec_off),
        .wdata      (bus_wdata),
        .rdata      (bank_rdata),
        .big_endian (be_fb)
    );

    // Size-dependent lane mask for identification reads.
    assign lane_on = cap_size[1] ? 4'hF : (cap_size[0] ? 4'h3 : 4'h1);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign id_masked[8*g +: 8] = lane_on[g] ? id_rdata[8*g +: 8] : 8'h00;
    end

    // Sequencer: accept, run downstream cycles, gather read data, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_wr     <= 1'b0;
            cap_off   <= '0;
            cap_size  <= '0;
            cap_wdata <= '0;
            cnt       <= '0;
            last      <= '0;
            rd_buf    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (acc) begin
                    op_wr     <= bus_wr;
                    cap_off   <= dec_off;
                    cap_size  <= bus_size;
                    cap_wdata <= bus_wdata;
                    cnt       <= '0;
                    last      <= 2'(size_bytes(bus_size) - 3'd1);
                    rd_buf    <= '0;
                    unique case (region)
                        RG_LEG:   state <= S_LEG;
                        RG_XMODE: state <= S_XIDX;
                        RG_ID:    if (bus_wr) done_q <= 1'b1;
                                  else state <= S_IDRD;
                        RG_XBANK: begin
                            if (!bus_wr) rd_buf <= bank_rdata;
                            done_q <= 1'b1;
                        end
                        default:  done_q <= 1'b1;
                    endcase
                end
                S_LEG: begin
                    if (!op_wr) rd_buf[{cnt, 3'b000} +: 8] <= lp_rdata;
                    cnt <= cnt + 2'd1;
                    if (cnt == last) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end
                end
                S_XIDX: state <= S_XDAT;
                S_XDAT: begin
                    if (!op_wr) rd_buf <= {16'h0000, xm_rdata};
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end
                S_IDRD: begin
                    rd_buf <= id_masked;
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Downstream strobes and addresses, decoded from the sequencer state.
    assign lp_rd     = state == S_LEG && !op_wr;
    assign lp_wr     = state == S_LEG && op_wr;
    assign lp_addr   = PORT_W'(PORT_BASE) + PORT_W'(cap_off) + PORT_W'(cnt);
    assign lp_wdata  = cap_wdata[{cnt, 3'b000} +: 8];
    assign xm_idx_wr = state == S_XIDX;
    assign xm_idx    = XIDX_W'(cap_off >> 1);
    assign xm_rd     = state == S_XDAT && !op_wr;
    assign xm_wr     = state == S_XDAT && op_wr;
    assign xm_wdata  = cap_wdata[15:0];
    assign id_rd     = state == S_IDRD;
    assign id_addr   = ID_AW'(cap_off);

    // Bus-side results.
    assign bus_busy  = state != S_IDLE;
    assign bus_done  = done_q;
    assign bus_rdata = rd_buf;
    assign rev_id    = xb_en ? 8'(EXT_REV) : 8'(BASE_REV);
endmodule

// File: rtl/mpb_checker.sv
// Protocol checker for the aperture bridge, bound to every instance.
// Watches only ports, so it is independent of the internal encoding.
module mpb_checker #(
    parameter int PORT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_busy,
    input logic              bus_done,
    input logic              lp_rd,
    input logic              lp_wr,
    input logic [PORT_W-1:0] lp_addr,
    input logic              xm_idx_wr,
    input logic              xm_rd,
    input logic              xm_wr,
    input logic              id_rd,
    input logic              be_fb
);
    logic any_strobe;
    assign any_strobe = lp_rd | lp_wr | xm_idx_wr | xm_rd | xm_wr | id_rd;

    // R5: never two downstream cycles at once
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lp_rd, lp_wr, xm_idx_wr, xm_rd, xm_wr, id_rd}));

    // R5: every downstream cycle happens under busy
    a_r5_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> bus_busy);

    // R6: an index cycle is always followed by a data cycle
    a_r6_index_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        xm_idx_wr |=> (xm_rd || xm_wr));

    // R3: back-to-back port cycles walk up one port at a time
    a_r3_ascending_ports: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_rd || lp_wr) && $past(lp_rd || lp_wr)) |-> (lp_addr == $past(lp_addr) + PORT_W'(1)));

    // R8: the byte-order flag moves only after an accepted write
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_busy) |=> $stable(be_fb));

    // R11: completion is reported only once the bridge is idle again
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |-> !bus_busy);
endmodule

bind mmio_port_bridge mpb_checker #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_busy  (bus_busy),
    .bus_done  (bus_done),
    .lp_rd     (lp_rd),
    .lp_wr     (lp_wr),
    .lp_addr   (lp_addr),
    .xm_idx_wr (xm_idx_wr),
    .xm_rd     (xm_rd),
    .xm_wr     (xm_wr),
    .id_rd     (id_rd),
    .be_fb     (be_fb)
);

// File: tb/mmio_port_bridge_tb.sv
`timescale 1ns/1ps
module mmio_port_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_en, xb_en;
    logic        bus_rd, bus_wr;
    logic [10:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        bus_busy, bus_done;
    logic [31:0] bus_rdata;
    logic        lp_rd, lp_wr;
    logic [9:0]  lp_addr;
    logic [7:0]  lp_wdata, lp_rdata;
    logic        xm_idx_wr, xm_rd, xm_wr;
    logic [7:0]  xm_idx;
    logic [15:0] xm_wdata, xm_rdata;
    logic        id_rd;
    logic [7:0]  id_addr;
    logic [31:0] id_rdata;
    logic        be_fb;
    logic [7:0]  rev_id;
    logic [7:0]  tb_idx;

    always #4 clk = ~clk;

    mmio_port_bridge u_dut (.*);

    // Downstream models.
    assign lp_rdata = lp_addr[7:0] ^ 8'h5A;
    assign xm_rdata = {8'hA5, tb_idx};
    assign id_rdata = {4{id_addr}} ^ 32'h1357_9BDF;
    always_ff @(posedge clk) if (!rst_n) tb_idx <= 8'h00; else if (xm_idx_wr) tb_idx <= xm_idx;

    int n_chk = 0, n_bad = 0;
    int ev_n, lat;
    int ev_kind [8];
    int ev_addr [8];
    int ev_data [8];
    int ev_k    [8];
    logic [31:0] rdv;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_ev(input int kind, input int a, input int d, input int k);
        if (ev_n < 8) begin
            ev_kind[ev_n] = kind; ev_addr[ev_n] = a; ev_data[ev_n] = d; ev_k[ev_n] = k;
        end
        ev_n++;
    endtask

    // One access; logs strobes at falling edges, k = edges since acceptance.
    task automatic access(input bit wr, input logic [10:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input bit stray);
        bit got = 0;
        ev_n = 0; lat = -1; rdv = '0;
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        for (int k = 0; k < 20 && !got; k++) begin
            if (stray && k == 0) begin
                bus_wr = 1; bus_addr = 11'h404; bus_size = 2'd0; bus_wdata = 32'hFF;
            end
            if (stray && k == 1) bus_wr = 0;
            if (lp_rd)     add_ev(1, lp_addr, 0, k);
            if (lp_wr)     add_ev(2, lp_addr, lp_wdata, k);
            if (xm_idx_wr) add_ev(3, xm_idx, 0, k);
            if (xm_rd)     add_ev(4, tb_idx, 0, k);
            if (xm_wr)     add_ev(5, tb_idx, xm_wdata, k);
            if (id_rd)     add_ev(6, id_addr, 0, k);
            if (bus_done) begin
                got = 1; lat = k; rdv = bus_rdata;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return sz[1] ? 4 : (sz[0] ? 2 : 1);
    endfunction

    task automatic ev_is(input int i, input int kind, input int a, input int d, input int k, input string req);
        chk(i < ev_n && ev_kind[i] == kind && ev_addr[i] == a && ev_data[i] == d && ev_k[i] == k,
            req, {ev_kind[i], ev_addr[i], ev_data[i], ev_k[i]}, {kind, a, d, k});
    endtask

    // Legacy window: R2 (single byte), R3 (ordered writes), R4 (read assembly).
    task automatic check_leg(input bit wr, input int n, input logic [1:0] sz, input logic [31:0] wd, input bit stray);
        int nb = nbytes(sz);
        logic [31:0] exp_rd = '0;
        string req = (nb == 1) ? "R2" : (wr ? "R3" : "R4");
        access(wr, 11'(32'h400 + n), sz, wd, stray);
        chk(ev_n == nb, stray ? "R5 stray dropped" : req, ev_n, nb);
        chk(lat == nb, req, lat, nb);
        for (int k = 0; k < nb; k++) begin
            int port = 32'h3C0 + n + k;
            ev_is(k, wr ? 2 : 1, port, wr ? int'(wd[8*k +: 8]) : 0, k, req);
            exp_rd[8*k +: 8] = 8'(port) ^ 8'h5A;
        end
        if (!wr) chk(rdv == exp_rd, "R4", rdv, exp_rd);
    endtask

    // Extended-mode window: R6.
    task automatic check_xm(input bit wr, input int m, input logic [31:0] wd);
        int idx = m >> 1;
        access(wr, 11'(32'h500 + m), 2'd1, wd, 0);
        chk(ev_n == 2 && lat == 2, "R6 count/latency", {ev_n, lat}, {2, 2});
        ev_is(0, 3, idx, 0, 0, "R6 index");
        ev_is(1, wr ? 5 : 4, idx, wr ? int'(wd[15:0]) : 0, 1, "R6 data");
        if (!wr) chk(rdv == {16'h0, 8'hA5, 8'(idx)}, "R6 read", rdv, {16'h0, 8'hA5, 8'(idx)});
    endtask

    // Accesses answered without a downstream cycle: R7, R8, R9, R11.
    task automatic check_local(input bit wr, input logic [10:0] a, input logic [1:0] sz,
                               input logic [31:0] wd, input logic [31:0] exp, input string req);
        access(wr, a, sz, wd, 0);
        chk(ev_n == 0 && lat == 0, req, {ev_n, lat}, 0);
        if (!wr) chk(rdv == exp, req, rdv, exp);
    endtask

    // Identification region: R10.
    task automatic check_id(input logic [10:0] a, input logic [1:0] sz);
        logic [31:0] full = {4{a[7:0]}} ^ 32'h1357_9BDF;
        logic [31:0] exp = sz[1] ? full : (sz[0] ? {16'h0, full[15:0]} : {24'h0, full[7:0]});
        access(0, a, sz, 0, 0);
        chk(ev_n == 1 && lat == 1, "R10 count/latency", {ev_n, lat}, {1, 1});
        ev_is(0, 6, a[7:0], 0, 0, "R10 address");
        chk(rdv == exp, "R10 data", rdv, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; id_en = 1; xb_en = 1; bus_rd = 0; bus_wr = 0;
        bus_addr = '0; bus_size = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        chk(!bus_busy && !bus_done && !be_fb && !lp_rd && !lp_wr && !xm_idx_wr && !id_rd,
            "R1 in reset", {bus_busy, bus_done, be_fb}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_busy && !bus_done && !be_fb, "R1 after reset", {bus_busy, bus_done, be_fb}, 0);
        chk(rev_id == 8'd2, "R12 enabled", rev_id, 2);

        // Legacy sweeps over all offsets and sizes.
        for (int n = 0; n < 32; n++) begin
            check_leg(1, n, 2'd0, 32'h0000_0000 | (n * 7 + 3), 0);
            check_leg(0, n, 2'd0, 0, 0);
        end
        for (int n = 0; n < 32; n += 2) begin
            check_leg(1, n, 2'd1, 32'h0000_1100 * n + 32'h0000_2211, 0);
            check_leg(0, n, 2'd1, 0, 0);
        end
        for (int n = 0; n < 32; n += 4) begin
            check_leg(1, n, 2'd2, 32'h4433_2211 + n, 0);
            check_leg(0, n, 2'd3, 0, 0);
        end
        // R5: a strobe during a split write is dropped
        check_leg(1, 8, 2'd2, 32'hDDCC_BBAA, 1);

        // Extended-mode sweep.
        for (int m = 0; m < 22; m += 2) begin
            check_xm(1, m, 32'hFFFF_0000 | (16'h1000 + m));
            check_xm(0, m, 0);
        end
        check_xm(0, 5, 0);

        // Extension bank.
        check_local(0, 11'h600, 2'd2, 0, 32'd8, "R7 size");
        check_local(0, 11'h604, 2'd2, 0, 32'h1E1E_1E1E, "R8 reset code");
        check_local(1, 11'h604, 2'd2, 32'hBEBE_BEBE, 0, "R8 write big");
        chk(be_fb == 1'b1, "R8 flag big", be_fb, 1);
        check_local(0, 11'h604, 2'd2, 0, 32'hBEBE_BEBE, "R8 read big");
        check_local(1, 11'h604, 2'd2, 32'h1234_5678, 0, "R8 other value");
        chk(be_fb == 1'b1, "R8 other value ignored", be_fb, 1);
        check_local(1, 11'h604, 2'd1, 32'h1E1E_1E1E, 0, "R9 narrow write");
        chk(be_fb == 1'b1, "R9 narrow write ignored", be_fb, 1);
        check_local(1, 11'h600, 2'd2, 32'h1E1E_1E1E, 0, "R9 size offset write");
        chk(be_fb == 1'b1, "R9 size offset write ignored", be_fb, 1);
        check_local(0, 11'h600, 2'd2, 0, 32'd8, "R9 size unchanged");
        check_local(0, 11'h602, 2'd2, 0, 0, "R9 other offset");
        check_local(0, 11'h601, 2'd3, 0, 0, "R9 other offset");
        check_local(0, 11'h600, 2'd0, 0, 0, "R9 narrow read");
        check_local(1, 11'h604, 2'd2, 32'h1E1E_1E1E, 0, "R8 write little");
        chk(be_fb == 1'b0, "R8 flag little", be_fb, 0);

        // Identification region.
        check_id(11'h000, 2'd0);
        check_id(11'h0FF, 2'd1);
        check_id(11'h080, 2'd2);
        check_local(1, 11'h010, 2'd2, 32'hFFFF_FFFF, 0, "R10 write no cycle");

        // Unmapped offsets.
        check_local(0, 11'h100, 2'd2, 0, 0, "R11 unmapped");
        check_local(0, 11'h420, 2'd0, 0, 0, "R11 unmapped");
        check_local(0, 11'h516, 2'd1, 0, 0, "R11 unmapped");
        check_local(0, 11'h608, 2'd2, 0, 0, "R11 unmapped");
        check_local(1, 11'h7FC, 2'd2, 32'h1234, 0, "R11 unmapped");

        // Disabled regions.
        id_en = 0; xb_en = 0;
        @(negedge clk);
        chk(rev_id == 8'd1, "R12 disabled", rev_id, 1);
        check_local(0, 11'h000, 2'd2, 0, 0, "R11 id disabled");
        check_local(0, 11'h600, 2'd2, 0, 0, "R11 bank disabled");
        check_local(1, 11'h604, 2'd2, 32'hBEBE_BEBE, 0, "R11 bank disabled write");
        chk(be_fb == 1'b0, "R11 disabled write ignored", be_fb, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule